// File: doc/BRIEF.md
# Configurable Output Macrocell for a Sum-of-Products Logic Device

This block is one output cell of a small programmable logic device. An AND array outside the block supplies a vector of product-term results. Static configuration bits choose how the cell behaves:

- **Registered:** the cell registers an OR of those terms.
- **Combinational:** the cell passes an OR of those terms straight through.
- **Input:** the cell turns its pin into an input only.

The block drives a tri-state pad as a data bit plus an enable bit. It also returns a feedback bit to the array.

How the terms are split depends on the mode:

- **Registered:** every term feeds the OR gate. A shared clock loads the flip-flop. A shared active-low enable pin gates the pad driver. The pad carries the inverted flip-flop output.
- **Combinational:** term 0 becomes the pad enable, and the remaining terms form the sum.
- **Input:** the driver is held off.

In every mode, a polarity bit can invert the sum before it reaches the flip-flop or the pad.

Top module: `pld_out_cell`

## Requirements
- R1: While `rst` is high at a rising clock edge, the flip-flop is cleared. With `cfg_mode` = 2'b00, this gives `pin_out` = 1 and `fb_out` = 0 after that edge.
- R2: With `cfg_mode` = 2'b00 (registered), each rising edge loads Q with (OR of all N_PT bits of `pt_in`) XOR `cfg_invert`. After the edge, `pin_out` equals NOT Q and `fb_out` equals Q.
- R3: With `cfg_mode` = 2'b00, `pin_oe` equals NOT `oe_n` and changes without waiting for a clock.
- R4: With `cfg_mode` = 2'b01 (combinational), `pin_out` equals (OR of `pt_in[N_PT-1:1]`) XOR `cfg_invert` within the same cycle, and `pt_in[0]` has no effect on it.
- R5: With `cfg_mode` = 2'b01, `pin_oe` equals `pt_in[0]`, and `oe_n` has no effect on `pin_oe` or `pin_out`.
- R6: With `cfg_mode` = 2'b10 or 2'b11 (input), `pin_oe` and `pin_out` are both 0 whatever the values of `pt_in`, `oe_n` and `cfg_invert`.
- R7: With `cfg_mode` other than 2'b00, `fb_out` equals `pin_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared device clock |
| rst | input | 1 | Synchronous active-high reset of the flip-flop |
| cfg_mode | input | 2 | 00 registered, 01 combinational, 10/11 input |
| cfg_invert | input | 1 | Inverts the sum term when 1 |
| pt_in | input | N_PT | Product-term results from the AND array |
| oe_n | input | 1 | Shared active-low output-enable pin |
| pin_in | input | 1 | Value currently seen on the pad |
| pin_out | output | 1 | Data driven towards the pad |
| pin_oe | output | 1 | Pad driver enable |
| fb_out | output | 1 | Feedback bit to the AND array |

## Verification
A wrong flip-flop value shows up one edge after the faulty load. In registered mode it appears on both `pin_out` and `fb_out`, which move in opposite directions. A wrong term split appears at once in combinational mode when only term 0 is set: the sum would then wrongly go high, or the enable would follow the global pin instead of term 0. A feedback source picked from the wrong place is visible the moment the pad input and the flip-flop disagree.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;
  typedef enum logic [1:0] {
    MODE_REG  = 2'b00,
    MODE_COMB = 2'b01,
    MODE_IN   = 2'b10,
    MODE_IN2  = 2'b11
  } cell_mode_e;

  function automatic logic is_input(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/pld_term_alloc.sv
module pld_term_alloc #(
  parameter int N_PT = 8
) (
  input  logic            invert,
  input  logic [N_PT-1:0] pt,
  output logic            sum_all,
  output logic            sum_rest,
  output logic            pt_oe
);
  // Running OR chains: one over every term, one that skips term 0.
  logic [N_PT-1:0] chain_all;
  logic [N_PT-1:0] chain_rest;

  assign chain_all[0]  = pt[0];
  assign chain_rest[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 1; gi < N_PT; gi++) begin : g_or
      assign chain_all[gi]  = chain_all[gi-1] | pt[gi];
      assign chain_rest[gi] = chain_rest[gi-1] | pt[gi];
    end
  endgenerate

  assign sum_all  = chain_all[N_PT-1]  ^ invert;
  assign sum_rest = chain_rest[N_PT-1] ^ invert;
  assign pt_oe    = pt[0];
endmodule

// File: rtl/pld_cell_ff.sv
module pld_cell_ff (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end

  // R1: reset clears the state after the edge
  a_r1_reset_clear: assert property (@(posedge clk) rst |=> !q);
endmodule

// File: rtl/pld_pin_mux.sv
module pld_pin_mux
  import pld_cell_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       oe_n,
  input  logic       q,
  input  logic       sum_rest,
  input  logic       pt_oe,
  input  logic       pin_in,
  output logic       pin_out,
  output logic       pin_oe,
  output logic       fb_out
);
  always_comb begin
    pin_out = 1'b0;
    pin_oe  = 1'b0;
    fb_out  = pin_in;
    if (!is_input(mode)) begin
      if (mode == MODE_REG) begin
        pin_out = ~q;
        pin_oe  = ~oe_n;
        fb_out  = q;
      end else begin
        pin_out = sum_rest;
        pin_oe  = pt_oe;
      end
    end
  end
endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
  import pld_cell_pkg::*;
#(
  parameter int N_PT = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      cfg_mode,
  input  logic            cfg_invert,
  input  logic [N_PT-1:0] pt_in,
  input  logic            oe_n,
  input  logic            pin_in,
  output logic            pin_out,
  output logic            pin_oe,
  output logic            fb_out
);
  logic sum_all;
  logic sum_rest;
  logic pt_oe;
  logic q;

  pld_term_alloc #(.N_PT(N_PT)) u_alloc (
    .invert   (cfg_invert),
    .pt       (pt_in),
    .sum_all  (sum_all),
    .sum_rest (sum_rest),
    .pt_oe    (pt_oe)
  );

  pld_cell_ff u_ff (
    .clk (clk),
    .rst (rst),
    .d   (sum_all),
    .q   (q)
  );

  pld_pin_mux u_mux (
    .mode     (cfg_mode),
    .oe_n     (oe_n),
    .q        (q),
    .sum_rest (sum_rest),
    .pt_oe    (pt_oe),
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .fb_out   (fb_out)
  );

  // R2: the pad shows the inverse of the sum captured one edge earlier
  a_r2_reg_path: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == MODE_REG && !$past(rst)) |-> (pin_out == !$past(sum_all)));

  // R2: feedback and pad data are complementary in registered mode
  a_r2_fb_complement: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == MODE_REG) |-> (fb_out != pin_out));

  // R3: the global enable pin gates the driver in registered mode
  a_r3_global_oe: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == MODE_REG) |-> (pin_oe == !oe_n));

  // R5: term 0 gates the driver in combinational mode
  a_r5_term_oe: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == MODE_COMB) |-> (pin_oe == pt_in[0]));

  // R6: the driver stays off in input mode
  a_r6_input_off: assert property (@(posedge clk) disable iff (rst)
    cfg_mode[1] |-> (!pin_oe && !pin_out));

  // R7: feedback comes from the pad outside registered mode
  a_r7_pad_fb: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode != MODE_REG) |-> (fb_out == pin_in));
endmodule

// File: tb/test_pld_out_cell.sv
module test_pld_out_cell;
  localparam int N_PT = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [1:0]      cfg_mode = 2'b00;
  logic            cfg_invert = 1'b0;
  logic [N_PT-1:0] pt_in = '0;
  logic            oe_n = 1'b1;
  logic            pin_in = 1'b0;
  logic            pin_out;
  logic            pin_oe;
  logic            fb_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  pld_out_cell #(.N_PT(N_PT)) i_pld_out_cell (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_invert(cfg_invert),
    .pt_in(pt_in), .oe_n(oe_n), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic edge_wait();
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    cfg_mode = 2'b00;
    pt_in = '1;
    rst = 1'b1;
    edge_wait();
    check("R1 pin_out", pin_out, 1'b1);
    check("R1 fb_out", fb_out, 1'b0);
    edge_wait();
    check("R1 held pin_out", pin_out, 1'b1);
    rst = 1'b0;
  endtask

  task automatic t_registered();
    logic [N_PT-1:0] v;
    logic e;
    cfg_mode = 2'b00;
    for (int i = 0; i < 60; i++) begin
      if (i < 2) v = '0;
      else if (i < 2 + N_PT) v = N_PT'(1) << (i - 2);
      else v = N_PT'($urandom);
      cfg_invert = i[0];
      pt_in = v;
      e = (|v) ^ cfg_invert;
      edge_wait();
      check("R2 pin_out", pin_out, ~e);
      check("R2 fb_out", fb_out, e);
    end
    // R2: output holds until the next edge
    pt_in = ~pt_in;
    #1;
    check("R2 hold", fb_out, e);
    edge_wait();
    for (int k = 0; k < 2; k++) begin
      oe_n = k[0];
      #1;
      check("R3 pin_oe", pin_oe, ~oe_n);
    end
  endtask

  task automatic t_combinational();
    logic [N_PT-1:0] v;
    cfg_mode = 2'b01;
    for (int i = 0; i < 60; i++) begin
      if (i == 0) v = N_PT'(1);
      else if (i == 1) v = '0;
      else v = N_PT'($urandom);
      pt_in = v;
      cfg_invert = i[1];
      oe_n = i[2];
      #1;
      check("R4 pin_out", pin_out, (|v[N_PT-1:1]) ^ cfg_invert);
      check("R5 pin_oe", pin_oe, v[0]);
      #3;
    end
    // R5: oe_n toggling has no effect
    pt_in = N_PT'(2);
    cfg_invert = 1'b0;
    oe_n = 1'b0;
    #1;
    check("R5 oe_n low ignored", pin_oe, 1'b0);
    oe_n = 1'b1;
    pt_in = N_PT'(3);
    #1;
    check("R5 oe_n high ignored", pin_oe, 1'b1);
    check("R5 data", pin_out, 1'b1);
  endtask

  task automatic t_input();
    for (int m = 2; m < 4; m++) begin
      cfg_mode = m[1:0];
      for (int i = 0; i < 20; i++) begin
        pt_in = N_PT'($urandom);
        oe_n = i[0];
        cfg_invert = i[1];
        edge_wait();
        check("R6 pin_oe", pin_oe, 1'b0);
        check("R6 pin_out", pin_out, 1'b0);
      end
    end
  endtask

  task automatic t_feedback();
    for (int m = 1; m < 4; m++) begin
      cfg_mode = m[1:0];
      for (int b = 0; b < 2; b++) begin
        pin_in = b[0];
        #1;
        check("R7 fb_out", fb_out, pin_in);
      end
    end
    // in registered mode feedback follows Q, not the pad
    cfg_mode = 2'b00;
    cfg_invert = 1'b0;
    pt_in = '0;
    pin_in = 1'b1;
    edge_wait();
    check("R7 reg fb ignores pad", fb_out, 1'b0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_registered();
    t_combinational();
    t_input();
    t_feedback();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule